// File: doc/BRIEF.md
# Overlay Pixel Unpack and Blend

This block is a streaming overlay stage. It accepts 32-bit words of packed overlay pixels through a valid/ready handshake and splits each word into one, two or four pixels. It decodes each pixel into 8-bit red, green and blue plus an alpha value, and mixes the result over a video pixel that arrives with it. The container size (8, 16 or 32 bits per pixel) is set apart from the colour format. In an 8-bit container every pixel is a palette index. A colour format narrower than its container leaves padding bits, and the block ignores them.

A 256-entry palette is loaded in two steps. Software first writes an index to one register, then writes a 32-bit colour to another register, and that colour is stored at the latched index. Colour keying, per-pixel alpha and global alpha each have their own enable bit and can be combined. One video pixel is consumed for every overlay pixel, in the cycle `vid_take_o` is high. The blended pixel appears two cycles after that.

Top module: `ovl_blend`

## Requirements
- R1: While reset is asserted and after it is released, `word_ready_o` is 1 and `pix_valid_o` is 0 until a word is accepted.
- R2: The container code in `cfg_bpp_i` selects the number of pixels per word: 1 gives four 8-bit pixels, 2 gives two 16-bit pixels, 3 (and 0) gives one 32-bit pixel. Pixels leave least-significant first, one per cycle. `word_ready_o` stays 0 while a held word still has pixels after the current one.
- R3: With container code 1, every pixel is looked up in the palette, whatever the value of `cfg_fmt_i`.
- R4: Format codes 1 (565: red [15:11], green [10:5], blue [4:0]), 2 (555: red [14:10], green [9:5], blue [4:0]) and 3 (444: red [11:8], green [7:4], blue [3:0]) widen each field to 8 bits by repeating its top bits below it.
- R5: Format code 4, and the unused codes 0, 6 and 7, read a 32-bit pixel as alpha [31:23+1], red [23:16], green [15:8], blue [7:0].
- R6: A pulse on `pal_idx_we_i` latches `pal_wdata_i[7:0]` as the index. A later pulse on `pal_dat_we_i` stores `pal_wdata_i` at that index. Format code 5 and 8-bit containers look up pixel bits [7:0] and use the stored entry, laid out like R5.
- R7: Pixel bits above the format's width (bits [31:8] for indexed, [31:16] for 565, [31:15] for 555, [31:12] for 444) do not affect the output.
- R8: When `cfg_key_en_i` is 1 and the pixel matches `cfg_key_i`, the output equals the video pixel. The match compares bits [7:0] for indexed pixels, [15:0] for codes 1 to 3, and all 32 bits otherwise.
- R9: The per-pixel alpha is used only when `cfg_lalpha_en_i` is 1 and the pixel is indexed or 32-bit. Otherwise the local alpha is 255.
- R10: The effective alpha is round(local x global / 255). Global alpha is `cfg_galpha_i` when `cfg_galpha_en_i` is 1, and 255 otherwise.
- R11: Each channel of `pix_o` ({red, green, blue}) is round((a x overlay + (255 - a) x video) / 255). It is valid exactly two cycles after the cycle in which `vid_take_o` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 3 | Colour format code |
| cfg_bpp_i | input | 2 | Container size code |
| cfg_key_en_i | input | 1 | Colour key enable |
| cfg_lalpha_en_i | input | 1 | Per-pixel alpha enable |
| cfg_galpha_en_i | input | 1 | Global alpha enable |
| cfg_galpha_i | input | 8 | Global alpha value |
| cfg_key_i | input | 32 | Colour key value |
| pal_idx_we_i | input | 1 | Latch palette index from pal_wdata_i[7:0] |
| pal_dat_we_i | input | 1 | Store pal_wdata_i at the latched index |
| pal_wdata_i | input | 32 | Palette write data |
| word_valid_i | input | 1 | Overlay word valid |
| word_i | input | 32 | Packed overlay word |
| word_ready_o | output | 1 | Overlay word accepted when high with valid |
| vid_i | input | 24 | Video pixel {red, green, blue} |
| vid_take_o | output | 1 | vid_i is consumed this cycle |
| pix_valid_o | output | 1 | Blended pixel valid |
| pix_o | output | 24 | Blended pixel {red, green, blue} |

## Verification
The bench builds the block with its default parameters: 32-bit words and an 8-bit palette index. These values bring every container size, all five colour formats and the full 256-entry palette within reach. With the wide words, the bench can check padding bytes above narrow formats, keys that differ only in their upper bits, and back-to-back words whose four pixels stream out without a gap.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam logic [2:0] FMT_565  = 3'd1;
  localparam logic [2:0] FMT_555  = 3'd2;
  localparam logic [2:0] FMT_444  = 3'd3;
  localparam logic [2:0] FMT_IDX  = 3'd5;

  localparam logic [1:0] BPP_8  = 2'd1;
  localparam logic [1:0] BPP_16 = 2'd2;

  typedef enum logic [1:0] {CL_IDX = 2'd0, CL_16 = 2'd1, CL_32 = 2'd2} fmt_class_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  function automatic fmt_class_e fmt_class(input logic [2:0] fmt, input logic [1:0] bpp);
    if (bpp == BPP_8 || fmt == FMT_IDX) return CL_IDX;
    if (fmt == FMT_565 || fmt == FMT_555 || fmt == FMT_444) return CL_16;
    return CL_32;
  endfunction

  // round(x / 255) for x <= 255*255
  function automatic logic [7:0] div255(input logic [15:0] x);
    logic [16:0] y;
    y = {1'b0, x} + 17'd128;
    y = y + (y >> 8);
    return y[15:8];
  endfunction

  function automatic logic [7:0] mix_ch(input logic [7:0] a, input logic [7:0] o,
                                        input logic [7:0] v);
    logic [15:0] s;
    s = 16'(a) * 16'(o) + 16'(8'd255 - a) * 16'(v);
    return div255(s);
  endfunction

endpackage

// File: rtl/ovl_unpack.sv
module ovl_unpack
  import ovl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bpp_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              px_valid_o,
  output logic [WORD_W-1:0] px_o
);
  localparam int MAX_PIX = WORD_W / 8;
  localparam int CNT_W   = $clog2(MAX_PIX);

  logic [WORD_W-1:0] hold_q;
  logic              hold_valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx;
  logic              last;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    case (bpp_i)
      BPP_8:   last_idx = CNT_W'(MAX_PIX - 1);
      BPP_16:  last_idx = CNT_W'(MAX_PIX / 2 - 1);
      default: last_idx = '0;
    endcase
  end

  assign last         = (cnt_q == last_idx);
  assign word_ready_o = !hold_valid_q || last;
  assign px_valid_o   = hold_valid_q;

  always_comb begin
    px_o = '0;
    case (bpp_i)
      BPP_8: begin
        shifted   = hold_q >> (32'(cnt_q) * 8);
        px_o[7:0] = shifted[7:0];
      end
      BPP_16: begin
        shifted    = hold_q >> (32'(cnt_q) * 16);
        px_o[15:0] = shifted[15:0];
      end
      default: begin
        shifted = hold_q;
        px_o    = hold_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q       <= '0;
      hold_valid_q <= 1'b0;
      cnt_q        <= '0;
    end else if (word_valid_i && word_ready_o) begin
      hold_q       <= word_i;
      hold_valid_q <= 1'b1;
      cnt_q        <= '0;
    end else if (hold_valid_q) begin
      if (last) hold_valid_q <= 1'b0;
      else      cnt_q        <= cnt_q + 1'b1;
    end
  end

  p_hold_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_valid_q && !last |=> hold_valid_q && $stable(hold_q));

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_valid_q |-> cnt_q <= last_idx);

endmodule

// File: rtl/ovl_palette.sv
module ovl_palette #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [ENTRIES];
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (dat_we_i) mem[idx_q] <= wdata_i;
    rd_data_o <= mem[rd_addr_i];
  end

  p_pal_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i |=> mem[$past(idx_q)] == $past(wdata_i));

endmodule

// File: rtl/ovl_mix.sv
module ovl_mix
  import ovl_pkg::*;
(
  input  logic [2:0]  fmt_i,
  input  logic [1:0]  bpp_i,
  input  logic        key_en_i,
  input  logic        lalpha_en_i,
  input  logic        galpha_en_i,
  input  logic [7:0]  galpha_i,
  input  logic        key_hit_i,
  input  logic [31:0] px_i,
  input  logic [31:0] pal_i,
  input  logic [23:0] vid_i,
  output logic [23:0] pix_o
);
  fmt_class_e cls;
  argb_t      src;
  logic [7:0] a_loc, a_glb, a_eff;

  assign cls = fmt_class(fmt_i, bpp_i);

  always_comb begin
    src = px_i;
    if (cls == CL_IDX) begin
      src = pal_i;
    end else if (cls == CL_16) begin
      src.a = 8'hFF;
      case (fmt_i)
        FMT_565: begin
          src.r = {px_i[15:11], px_i[15:13]};
          src.g = {px_i[10:5],  px_i[10:9]};
          src.b = {px_i[4:0],   px_i[4:2]};
        end
        FMT_555: begin
          src.r = {px_i[14:10], px_i[14:12]};
          src.g = {px_i[9:5],   px_i[9:7]};
          src.b = {px_i[4:0],   px_i[4:2]};
        end
        default: begin
          src.r = {px_i[11:8], px_i[11:8]};
          src.g = {px_i[7:4],  px_i[7:4]};
          src.b = {px_i[3:0],  px_i[3:0]};
        end
      endcase
    end
  end

  always_comb begin
    a_loc = (lalpha_en_i && cls != CL_16) ? src.a : 8'hFF;
    a_glb = galpha_en_i ? galpha_i : 8'hFF;
    a_eff = (key_en_i && key_hit_i) ? 8'h00 : div255(16'(a_loc) * 16'(a_glb));
  end

  assign pix_o = {mix_ch(a_eff, src.r, vid_i[23:16]),
                  mix_ch(a_eff, src.g, vid_i[15:8]),
                  mix_ch(a_eff, src.b, vid_i[7:0])};

endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PAL_IDX_W = 8,
  parameter int PIX_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_fmt_i,
  input  logic [1:0]        cfg_bpp_i,
  input  logic              cfg_key_en_i,
  input  logic              cfg_lalpha_en_i,
  input  logic              cfg_galpha_en_i,
  input  logic [7:0]        cfg_galpha_i,
  input  logic [WORD_W-1:0] cfg_key_i,
  input  logic              pal_idx_we_i,
  input  logic              pal_dat_we_i,
  input  logic [WORD_W-1:0] pal_wdata_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  input  logic [PIX_W-1:0]  vid_i,
  output logic              vid_take_o,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  logic [WORD_W-1:0] px0;
  logic              key_hit0;
  fmt_class_e        cls0;

  logic              s1_valid;
  logic [WORD_W-1:0] s1_px;
  logic              s1_key_hit;
  logic [PIX_W-1:0]  s1_vid;
  logic [WORD_W-1:0] pal_rd;
  logic [PIX_W-1:0]  mix_pix;

  ovl_unpack #(.WORD_W(WORD_W)) i_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bpp_i        (cfg_bpp_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .word_ready_o (word_ready_o),
    .px_valid_o   (vid_take_o),
    .px_o         (px0)
  );

  assign cls0 = fmt_class(cfg_fmt_i, cfg_bpp_i);

  always_comb begin
    case (cls0)
      CL_IDX:  key_hit0 = (px0[7:0] == cfg_key_i[7:0]);
      CL_16:   key_hit0 = (px0[15:0] == cfg_key_i[15:0]);
      default: key_hit0 = (px0 == cfg_key_i);
    endcase
  end

  ovl_palette #(.IDX_W(PAL_IDX_W), .DATA_W(WORD_W)) i_palette (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_we_i  (pal_idx_we_i),
    .dat_we_i  (pal_dat_we_i),
    .wdata_i   (pal_wdata_i),
    .rd_addr_i (px0[PAL_IDX_W-1:0]),
    .rd_data_o (pal_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_px      <= '0;
      s1_key_hit <= 1'b0;
      s1_vid     <= '0;
    end else begin
      s1_valid <= vid_take_o;
      if (vid_take_o) begin
        s1_px      <= px0;
        s1_key_hit <= key_hit0;
        s1_vid     <= vid_i;
      end
    end
  end

  ovl_mix i_mix (
    .fmt_i       (cfg_fmt_i),
    .bpp_i       (cfg_bpp_i),
    .key_en_i    (cfg_key_en_i),
    .lalpha_en_i (cfg_lalpha_en_i),
    .galpha_en_i (cfg_galpha_en_i),
    .galpha_i    (cfg_galpha_i),
    .key_hit_i   (s1_key_hit),
    .px_i        (s1_px[31:0]),
    .pal_i       (pal_rd[31:0]),
    .vid_i       (s1_vid),
    .pix_o       (mix_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_o       <= '0;
    end else begin
      pix_valid_o <= s1_valid;
      if (s1_valid) pix_o <= mix_pix;
    end
  end

  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_take_o |=> ##1 pix_valid_o);

  p_no_spurious_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vid_take_o |=> ##1 !pix_valid_o);

  p_key_video_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid && s1_key_hit && cfg_key_en_i |=> pix_o == $past(s1_vid));

endmodule

// File: tb/test_ovl_blend.sv
module test_ovl_blend;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [1:0]  bpp;
    logic        key_en;
    logic        la_en;
    logic        ga_en;
    logic [7:0]  ga;
    logic [31:0] key;
    logic [31:0] word;
    logic [23:0] vid;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'hF800_07E0, 24'h204060},
    '{3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'h7C00_801F, 24'h102030},
    '{3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'hAF00_50A3, 24'h0A0B0C},
    '{3'd4, 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0,         32'h8011_2233, 24'h102030},
    '{3'd4, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'h0044_5566, 24'hFFFFFF},
    '{3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'h0302_0100, 24'h406080},
    '{3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0,         32'hFFFF_FF07, 24'h112233},
    '{3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 8'h00, 32'hABCD_1234, 32'h1234_5678, 24'h556677},
    '{3'd4, 2'd3, 1'b0, 1'b1, 1'b1, 8'h40, 32'h0,         32'hC0FF_00FF, 24'h204080},
    '{3'd5, 2'd1, 1'b1, 1'b1, 1'b1, 8'h80, 32'h0000_0002, 32'h0201_0203, 24'h8090A0},
    '{3'd1, 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0,         32'hFF00_F81F, 24'h000000}
  };
  localparam string TAG [NV] = '{"R2 R4", "R4 R7", "R4 R7", "R5 R9 R11", "R5 R11",
                                 "R3 R6", "R7 R6", "R8", "R10 R9", "R8 R9 R10", "R9 R7"};

  logic        clk, rst_n;
  logic [2:0]  cfg_fmt;
  logic [1:0]  cfg_bpp;
  logic        cfg_key_en, cfg_la_en, cfg_ga_en;
  logic [7:0]  cfg_ga;
  logic [31:0] cfg_key;
  logic        pal_idx_we, pal_dat_we;
  logic [31:0] pal_wdata;
  logic        word_valid, word_ready;
  logic [31:0] word;
  logic [23:0] vid;
  logic        vid_take, pix_valid;
  logic [23:0] pix;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] pal_m [256];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  ovl_blend i_ovl_blend (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_fmt_i(cfg_fmt), .cfg_bpp_i(cfg_bpp), .cfg_key_en_i(cfg_key_en),
    .cfg_lalpha_en_i(cfg_la_en), .cfg_galpha_en_i(cfg_ga_en), .cfg_galpha_i(cfg_ga),
    .cfg_key_i(cfg_key), .pal_idx_we_i(pal_idx_we), .pal_dat_we_i(pal_dat_we),
    .pal_wdata_i(pal_wdata), .word_valid_i(word_valid), .word_i(word),
    .word_ready_o(word_ready), .vid_i(vid), .vid_take_o(vid_take),
    .pix_valid_o(pix_valid), .pix_o(pix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int rdiv255(input int x);
    return (2 * x + 255) / 510;
  endfunction

  function automatic logic [23:0] model(input logic [31:0] p, input logic [23:0] v);
    bit is_idx, is16, hit;
    int r, g, b, la, ga, a;
    logic [31:0] e;
    is_idx = (cfg_bpp == 2'd1) || (cfg_fmt == 3'd5);
    is16   = !is_idx && (cfg_fmt >= 3'd1 && cfg_fmt <= 3'd3);
    la = 255;
    if (is_idx) begin
      e = pal_m[p[7:0]];
      r = e[23:16]; g = e[15:8]; b = e[7:0]; la = e[31:24];
      hit = p[7:0] == cfg_key[7:0];
    end else if (is16) begin
      hit = p[15:0] == cfg_key[15:0];
      if (cfg_fmt == 3'd1) begin
        r = (32'(p[15:11]) << 3) | (32'(p[15:11]) >> 2);
        g = (32'(p[10:5]) << 2) | (32'(p[10:5]) >> 4);
        b = (32'(p[4:0]) << 3) | (32'(p[4:0]) >> 2);
      end else if (cfg_fmt == 3'd2) begin
        r = (32'(p[14:10]) << 3) | (32'(p[14:10]) >> 2);
        g = (32'(p[9:5]) << 3) | (32'(p[9:5]) >> 2);
        b = (32'(p[4:0]) << 3) | (32'(p[4:0]) >> 2);
      end else begin
        r = 17 * p[11:8]; g = 17 * p[7:4]; b = 17 * p[3:0];
      end
    end else begin
      r = p[23:16]; g = p[15:8]; b = p[7:0]; la = p[31:24];
      hit = p == cfg_key;
    end
    if (!cfg_la_en || is16) la = 255;
    ga = cfg_ga_en ? cfg_ga : 255;
    a  = (cfg_key_en && hit) ? 0 : rdiv255(la * ga);
    return {8'(rdiv255(a * r + (255 - a) * v[23:16])),
            8'(rdiv255(a * g + (255 - a) * v[15:8])),
            8'(rdiv255(a * b + (255 - a) * v[7:0]))};
  endfunction

  task automatic push_word(input logic [31:0] w, input string tag);
    int wd, n;
    logic [31:0] p;
    wd = (cfg_bpp == 2'd1) ? 8 : (cfg_bpp == 2'd2) ? 16 : 32;
    n  = 32 / wd;
    for (int k = 0; k < n; k++) begin
      p = w >> (k * wd);
      if (wd < 32) p = p & ((32'd1 << wd) - 1);
      exp_q.push_back(model(p, vid));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [31:0] w);
    bit ok;
    word = w;
    word_valid = 1'b1;
    forever begin
      ok = word_ready;
      @(negedge clk);
      if (ok) break;
    end
    word_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pal_write(input logic [7:0] idx, input logic [31:0] val);
    pal_idx_we = 1'b1; pal_wdata = {24'h0, idx};
    @(negedge clk);
    pal_idx_we = 1'b0; pal_dat_we = 1'b1; pal_wdata = val;
    @(negedge clk);
    pal_dat_we = 1'b0;
    pal_m[idx] = val;
  endtask

  task automatic set_cfg(input vec_t c);
    cfg_fmt = c.fmt; cfg_bpp = c.bpp; cfg_key_en = c.key_en;
    cfg_la_en = c.la_en; cfg_ga_en = c.ga_en; cfg_ga = c.ga; cfg_key = c.key;
    vid = c.vid;
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected output", {8'h0, pix}, 32'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pix === e, t, {8'h0, pix}, {8'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    word_valid = 1'b0; word = '0; vid = '0;
    pal_idx_we = 1'b0; pal_dat_we = 1'b0; pal_wdata = '0;
    set_cfg(VEC[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(word_ready === 1'b1, "R1 ready in reset", 32'(word_ready), 32'd1);
    check(pix_valid === 1'b0, "R1 valid in reset", 32'(pix_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_ready === 1'b1, "R1 ready after reset", 32'(word_ready), 32'd1);
    check(pix_valid === 1'b0, "R1 valid after reset", 32'(pix_valid), 32'd0);

    // R6: load palette through index then data
    for (int i = 0; i < 256; i++)
      pal_write(8'(i), {8'(i), 8'(i * 5), ~8'(i), 8'(i) ^ 8'h5A});

    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v]);
      push_word(VEC[v].word, TAG[v]);
      send(VEC[v].word);
      drain();
    end

    // R6: rewrite one entry and read it back through the stream
    pal_write(8'h07, 32'hFF12_3456);
    set_cfg(VEC[6]);
    push_word(VEC[6].word, "R6 rewrite");
    send(VEC[6].word);
    drain();

    // R2 R11: back-to-back words, ready drop and latency
    set_cfg(VEC[5]);
    push_word(32'h1111_2233, "R2 word A");
    send(32'h1111_2233);
    check(word_ready === 1'b0, "R2 ready low mid word", 32'(word_ready), 32'd0);
    check(pix_valid === 1'b0, "R11 latency t+0", 32'(pix_valid), 32'd0);
    @(negedge clk);
    check(pix_valid === 1'b0, "R11 latency t+1", 32'(pix_valid), 32'd0);
    @(negedge clk);
    check(pix_valid === 1'b1, "R11 latency t+2", 32'(pix_valid), 32'd1);
    push_word(32'hF0E0_D0C0, "R2 word B");
    send(32'hF0E0_D0C0);
    drain();

    check(exp_q.size() == 0, "R2 all pixels out", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule